// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block makes the acknowledge decision for the address phase of an I2C slave. The bus shift logic hands it each received byte with a strobe. A qualifier on the strobe says whether the byte is the first one after a START or repeated START, or the second one. The block compares the byte against a configured own address. It honours a per-bit don't-care mask, and a management enable switches that mask off. It rejects the protocol's reserved address patterns and accepts the general call only when that is enabled.

Both 7-bit and 10-bit addressing are supported. In 10-bit mode the header byte (pattern 11110 followed by address bits 9:8 and R/W) and the low address byte are each acknowledged on their own. After a complete 10-bit write match, a repeated START followed by the matching header with R/W=1 is accepted as a read. This read needs no second address byte. A STOP forgets that history.

The byte input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high while out of reset, and every cycle with `in_valid` high consumes one byte. The decision outputs are single-cycle pulses one clock after the consuming cycle. The captured R/W bit holds its value until the next first byte.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode, a first byte whose bits 7:1 equal `cfg_addr[6:0]` produces `ack` and `match`. Address bits whose `cfg_mask` bit is 1 are ignored in the compare. `rw` takes the received bit 0.
- R2: While `cfg_mgmt_en` is 1 the mask has no effect, in both 7-bit and 10-bit modes. An address that matches only through the mask is then refused.
- R3: A first byte of 0x00 is the general call. It produces `ack`, `match` and `gen_call` together when `cfg_gc_en` is 1, and nothing when it is 0. `gen_call` never appears without `match`.
- R4: A first byte of 0x01 (address 0000000 with R/W=1) is never acknowledged, whatever the mask or the enables.
- R5: First bytes with bits 7:1 equal to 0000001, 0000010, 0000011, 00001xx or 11111xx are never acknowledged, whatever the mask or `cfg_addr` hold. The check is made on the raw received bits.
- R6: A first byte with bits 7:3 equal to 11110 is never acknowledged in 7-bit mode (`cfg_ten_bit`=0). In 10-bit mode a first byte other than 11110xxx or the general call is refused.
- R7: In 10-bit mode, the header byte 11110 b9 b8 0 is acknowledged without `match` when its bits 2:1 equal `cfg_addr[9:8]` under the mask. A following second byte (`in_first`=0) equal to `cfg_addr[7:0]` under the mask then gives `ack` and `match`.
- R8: A second byte is refused if no acknowledged 10-bit header directly preceded it, or if it mismatches `cfg_addr[7:0]`.
- R9: After a full 10-bit match, a matching header with R/W=1 gives `ack` and `match` with `rw`=1. Without a prior full match, or after a STOP or reset, the same byte is refused.
- R10: `in_ready` is 1 while out of reset. `ack`, `match` and `gen_call` are 0 during reset. They are registered, rise one clock after the consuming cycle and last one cycle.
- R11: When `bus_stop` and `in_valid` are high in the same cycle, the STOP wins. The byte is not acknowledged and the 10-bit history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte is present |
| in_ready | output | 1 | Byte accepted (held high out of reset) |
| in_byte | input | 8 | Received byte, R/W in bit 0 for first bytes |
| in_first | input | 1 | 1: first byte after START/Sr, 0: second byte |
| bus_stop | input | 1 | One-cycle STOP indication |
| cfg_addr | input | 10 | Own address (bits 6:0 used in 7-bit mode) |
| cfg_mask | input | 10 | Don't-care mask, 1 = ignore bit |
| cfg_ten_bit | input | 1 | 1: 10-bit addressing |
| cfg_gc_en | input | 1 | Accept general call |
| cfg_mgmt_en | input | 1 | Management enable; disables masking |
| ack | output | 1 | Acknowledge this byte (pulse) |
| match | output | 1 | Address fully matched (pulse) |
| gen_call | output | 1 | Match was a general call (pulse) |
| rw | output | 1 | Captured R/W bit of the last first byte |

## Verification
The properties assume that `in_first` and `in_byte` are meaningful only in cycles where `in_valid` is high, and that `bus_stop` is a single-cycle pulse. They also assume configuration inputs change only between bytes. The reserved-pattern properties look only at the raw byte, so they hold whatever the mask and address hold. The stimulus drives all inputs at the falling edge and presents each byte for exactly one cycle. It changes configuration only together with a new byte, and it raises `bus_stop` alone except in the one case that deliberately overlaps it with a byte.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W  = 8;
  localparam int A7_W    = 7;
  localparam int A10_W   = 10;
  localparam int HI_W    = A10_W - BYTE_W;

  // class of a raw first byte, decided before any masking
  typedef enum logic [2:0] {
    CLS_NORMAL,
    CLS_GCALL,
    CLS_STARTB,
    CLS_RSVD,
    CLS_HDR10
  } head_cls_e;
endpackage

// File: rtl/i2c_am_classify.sv
module i2c_am_classify
  import i2c_am_pkg::*;
(
  input  logic [BYTE_W-1:0] head_byte,
  output head_cls_e         cls
);
  always_comb begin
    casez (head_byte[BYTE_W-1:1])
      7'b0000000: cls = head_byte[0] ? CLS_STARTB : CLS_GCALL;
      7'b0000001,
      7'b000001?,
      7'b00001??,
      7'b11111??: cls = CLS_RSVD;
      7'b11110??: cls = CLS_HDR10;
      default:    cls = CLS_NORMAL;
    endcase
  end
endmodule

// File: rtl/i2c_am_mcmp.sv
module i2c_am_mcmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx_bits,
  input  logic [W-1:0] own_bits,
  input  logic [W-1:0] dc_bits,
  output logic         hit
);
  assign hit = ((rx_bits ^ own_bits) & ~dc_bits) == '0;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_first,
  input  logic              bus_stop,
  input  logic [A10_W-1:0]  cfg_addr,
  input  logic [A10_W-1:0]  cfg_mask,
  input  logic              cfg_ten_bit,
  input  logic              cfg_gc_en,
  input  logic              cfg_mgmt_en,
  output logic              ack,
  output logic              match,
  output logic              gen_call,
  output logic              rw
);
  logic [A10_W-1:0] eff_mask;
  head_cls_e        cls;
  logic             hit7, hit_hi, hit_lo;

  // 10-bit history: header acked (awaiting low byte), full write match seen
  logic hdr_pend_q, full10_q;
  logic hdr_pend_d, full10_d;
  logic ack_d, match_d, gc_d, rw_d;

  assign eff_mask = cfg_mgmt_en ? '0 : cfg_mask;

  i2c_am_classify u_cls (
    .head_byte (in_byte),
    .cls       (cls)
  );

  i2c_am_mcmp #(.W(A7_W)) u_cmp7 (
    .rx_bits  (in_byte[BYTE_W-1:1]),
    .own_bits (cfg_addr[A7_W-1:0]),
    .dc_bits  (eff_mask[A7_W-1:0]),
    .hit      (hit7)
  );

  i2c_am_mcmp #(.W(HI_W)) u_cmp_hi (
    .rx_bits  (in_byte[HI_W:1]),
    .own_bits (cfg_addr[A10_W-1:BYTE_W]),
    .dc_bits  (eff_mask[A10_W-1:BYTE_W]),
    .hit      (hit_hi)
  );

  i2c_am_mcmp #(.W(BYTE_W)) u_cmp_lo (
    .rx_bits  (in_byte),
    .own_bits (cfg_addr[BYTE_W-1:0]),
    .dc_bits  (eff_mask[BYTE_W-1:0]),
    .hit      (hit_lo)
  );

  always_comb begin
    ack_d      = 1'b0;
    match_d    = 1'b0;
    gc_d       = 1'b0;
    rw_d       = rw;
    hdr_pend_d = hdr_pend_q;
    full10_d   = full10_q;
    if (bus_stop) begin
      hdr_pend_d = 1'b0;
      full10_d   = 1'b0;
    end else if (in_valid) begin
      hdr_pend_d = 1'b0;
      if (in_first) begin
        full10_d = 1'b0;
        rw_d     = in_byte[0];
        unique case (cls)
          CLS_GCALL: begin
            ack_d   = cfg_gc_en;
            match_d = cfg_gc_en;
            gc_d    = cfg_gc_en;
          end
          CLS_NORMAL: begin
            ack_d   = !cfg_ten_bit && hit7;
            match_d = !cfg_ten_bit && hit7;
          end
          CLS_HDR10: begin
            if (cfg_ten_bit && hit_hi) begin
              if (!in_byte[0]) begin
                ack_d      = 1'b1;
                hdr_pend_d = 1'b1;
              end else if (full10_q) begin
                ack_d    = 1'b1;
                match_d  = 1'b1;
                full10_d = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end else if (hdr_pend_q && hit_lo) begin
        ack_d    = 1'b1;
        match_d  = 1'b1;
        full10_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack        <= 1'b0;
      match      <= 1'b0;
      gen_call   <= 1'b0;
      rw         <= 1'b0;
      hdr_pend_q <= 1'b0;
      full10_q   <= 1'b0;
      in_ready   <= 1'b0;
    end else begin
      ack        <= ack_d;
      match      <= match_d;
      gen_call   <= gc_d;
      rw         <= rw_d;
      hdr_pend_q <= hdr_pend_d;
      full10_q   <= full10_d;
      in_ready   <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       in_first,
  input logic       bus_stop,
  input logic       cfg_ten_bit,
  input logic       cfg_gc_en,
  input logic       ack,
  input logic       match,
  input logic       gen_call
);
  a_r3_gc_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> match);

  a_r3_gc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && in_byte == 8'h00 && !cfg_gc_en) |=> !ack);

  a_r4_start_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && in_byte == 8'h01) |=> !ack);

  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first &&
     ((in_byte[7:3] == 5'b00000 && in_byte[7:1] != 7'd0) || in_byte[7:3] == 5'b11111))
    |=> !ack);

  a_r6_hdr_in_7bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && !cfg_ten_bit && in_byte[7:3] == 5'b11110) |=> !ack);

  a_r7_match_acked: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> ack);

  a_r10_quiet_without_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!ack && !match && !gen_call));

  a_r11_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !ack);
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (.*);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_first, bus_stop;
  logic [7:0] in_byte;
  logic [9:0] cfg_addr, cfg_mask;
  logic       cfg_ten_bit, cfg_gc_en, cfg_mgmt_en;
  logic       ack, match, gen_call, rw;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_match dut (.*);

  typedef struct packed {
    logic       vld, stp, ten, mgt, gce;
    logic [9:0] msk, adr;
    logic       fst;
    logic [7:0] dat;
    logic       e_ack, e_mat, e_gc, e_rw;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    // 7-bit, own address 0x52
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,10'h052,1'b1,8'hA4,1'b1,1'b1,1'b0,1'b0,4'd1},  // R1 write hit
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,10'h052,1'b1,8'hA5,1'b1,1'b1,1'b0,1'b1,4'd1},  // R1 read hit
    '{1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,10'h052,1'b1,8'hA5,1'b0,1'b0,1'b0,1'b0,4'd10}, // R10 pulse ends
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,10'h052,1'b1,8'hA6,1'b0,1'b0,1'b0,1'b0,4'd1},  // R1 miss
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h001,10'h052,1'b1,8'hA6,1'b1,1'b1,1'b0,1'b0,4'd1},  // R1 masked hit
    '{1'b1,1'b0,1'b0,1'b1,1'b0,10'h001,10'h052,1'b1,8'hA6,1'b0,1'b0,1'b0,1'b0,4'd2},  // R2 mask off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,10'h001,10'h052,1'b1,8'hA4,1'b1,1'b1,1'b0,1'b0,4'd2},  // R2 exact hit
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,10'h052,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,4'd3},  // R3 gc disabled
    '{1'b1,1'b0,1'b0,1'b0,1'b1,10'h000,10'h052,1'b1,8'h00,1'b1,1'b1,1'b1,1'b0,4'd3},  // R3 gc enabled
    '{1'b1,1'b0,1'b0,1'b0,1'b1,10'h3FF,10'h052,1'b1,8'h01,1'b0,1'b0,1'b0,1'b0,4'd4},  // R4 start byte
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h052,1'b1,8'h10,1'b1,1'b1,1'b0,1'b0,4'd1},  // R1 all don't-care
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h052,1'b1,8'h02,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 0000001
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h052,1'b1,8'h06,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 0000011
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h052,1'b1,8'h0C,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 00001xx
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h052,1'b1,8'hF8,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 11111xx
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h000,10'h001,1'b1,8'h02,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 own addr reserved
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h052,1'b1,8'hF0,1'b0,1'b0,1'b0,1'b0,4'd6},  // R6 header in 7-bit
    // 10-bit, own address 0x2B5 (header F4/F5)
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hA4,1'b0,1'b0,1'b0,1'b0,4'd6},  // R6 plain byte in 10-bit
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF4,1'b1,1'b0,1'b0,1'b0,4'd7},  // R7 header
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b0,8'hB5,1'b1,1'b1,1'b0,1'b0,4'd7},  // R7 low byte
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF5,1'b1,1'b1,1'b0,1'b1,4'd9},  // R9 read after Sr
    '{1'b0,1'b1,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF5,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9 stop
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF5,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9 read refused
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b0,8'hB5,1'b0,1'b0,1'b0,1'b0,4'd8},  // R8 orphan low byte
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF4,1'b1,1'b0,1'b0,1'b0,4'd7},  // R7 header
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b0,8'hB6,1'b0,1'b0,1'b0,1'b0,4'd8},  // R8 low mismatch
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF6,1'b0,1'b0,1'b0,1'b0,4'd7},  // R7 bit 8 differs
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h100,10'h2B5,1'b1,8'hF6,1'b1,1'b0,1'b0,1'b0,4'd7},  // R7 mask on bit 8
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h100,10'h2B5,1'b0,8'hB5,1'b1,1'b1,1'b0,1'b0,4'd7},  // R7 low byte
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF5,1'b1,1'b1,1'b0,1'b1,4'd9},  // R9 read
    '{1'b1,1'b1,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF5,1'b0,1'b0,1'b0,1'b0,4'd11}, // R11 stop with byte
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,1'b1,8'hF5,1'b0,1'b0,1'b0,1'b0,4'd11}, // R11 history gone
    '{1'b1,1'b0,1'b1,1'b1,1'b0,10'h100,10'h2B5,1'b1,8'hF6,1'b0,1'b0,1'b0,1'b0,4'd2},  // R2 mask off, 10-bit
    '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h3FF,10'h2B5,1'b1,8'hF8,1'b0,1'b0,1'b0,1'b0,4'd5}   // R5 11111xx, 10-bit
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid    = v.vld;
    bus_stop    = v.stp;
    cfg_ten_bit = v.ten;
    cfg_mgmt_en = v.mgt;
    cfg_gc_en   = v.gce;
    cfg_mask    = v.msk;
    cfg_addr    = v.adr;
    in_first    = v.fst;
    in_byte     = v.dat;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    bus_stop = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    drive(v);
    tag = $sformatf("R%0d", v.req);
    check(tag, "ack", ack, v.e_ack);
    check(tag, "match", match, v.e_mat);
    check(tag, "gen_call", gen_call, v.e_gc);
    if (v.e_mat) check(tag, "rw", rw, v.e_rw);
  endtask

  function automatic vec_t mk10(input logic fst, input logic [7:0] d);
    vec_t v;
    v = '{1'b1,1'b0,1'b1,1'b0,1'b0,10'h000,10'h2B5,fst,d,1'b0,1'b0,1'b0,1'b0,4'd9};
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; bus_stop = 1'b0; in_first = 1'b1; in_byte = 8'hA4;
    cfg_addr = 10'h052; cfg_mask = 10'h000;
    cfg_ten_bit = 1'b0; cfg_gc_en = 1'b1; cfg_mgmt_en = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state, with a would-be hit offered during reset
    in_valid = 1'b1;
    @(negedge clk);
    check("R10", "ack in reset", ack, 1'b0);
    check("R10", "match in reset", match, 1'b0);
    check("R10", "gen_call in reset", gen_call, 1'b0);
    check("R10", "rw in reset", rw, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "in_ready", in_ready, 1'b1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R10 output is registered: no ack in the consuming cycle
    in_valid = 1'b1; in_first = 1'b1; in_byte = 8'hA4;
    cfg_ten_bit = 1'b0; cfg_addr = 10'h052; cfg_mask = 10'h000; cfg_mgmt_en = 1'b0;
    #1;
    check("R10", "ack same cycle", ack, 1'b0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "ack next cycle", ack, 1'b1);

    // R9 reset clears 10-bit history
    drive(mk10(1'b1, 8'hF4));
    drive(mk10(1'b0, 8'hB5));
    check("R9", "low byte before reset", match, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(mk10(1'b1, 8'hF5));
    check("R9", "read after reset", ack, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule